// File: doc/BRIEF.md
# Twiddle-Factor Complex Rotator

This block sits between the first and second small-DFT stages of a 128-point mixed-radix FFT. It multiplies every streamed complex sample by a twiddle factor W^(m·s), with W = e^(−j2π/128). Here m (0..7) and s (0..15) are the row and column of the 8×16 index decomposition. The block does not compute the exponent per sample. A 7-bit sample counter walks a 128-entry coefficient table in natural order, in step with the data, and a start pulse brings the counter back to entry 0.

Each accepted sample passes through a three-register pipeline. The first register captures the sample and its coefficient pair. The second forms four real products. The third forms one difference and one sum, which are scaled back to the data width. All registers, the counter and the output advance only on clock edges where the enable is high. A parameter selects the conjugate twiddles for inverse transforms.

Top module: `twiddle_rotator`

## Requirements
- R1: While `rst` is high, `rdy` is 0 at every clock edge and the sample counter returns to 0. The first sample accepted after reset, with no start pulse, uses table entry 0.
- R2: At a clock edge with `start` high, the counter is set to 0 and no sample is accepted. If `ed` is also high, an empty slot enters the pipeline. The next accepted sample uses entry 0.
- R3: A sample is accepted at each edge with `ed`=1 and `start`=0. After each accepted sample the counter advances by one and wraps from 127 to 0. For counter value k, the row is m = k[6:4], the column is s = k[3:0], and the exponent is m·s mod 128.
- R4: For exponent e and θ = 2πe/128, the coefficient real part is wr = round(cos θ · 2^(COEF_W−1)). The sine term is sn = round(sin θ · 2^(COEF_W−1)). Rounding is half away from zero. Both values saturate at 2^(COEF_W−1)−1. In forward mode (INVERSE=0) the coefficient imaginary part is wi = −sn.
- R5: The output is re = ar·wr − ai·wi and im = ar·wi + ai·wr. Each is arithmetically shifted right by COEF_W−1 bits, which is floor truncation, and its low DATA_W bits are driven on `dor` and `doi` as two's complement.
- R6: The result of a sample accepted at an enabled edge appears on `dor`/`doi` after the second enabled edge that follows it, for three enabled edges in total. `rdy` is 1 exactly while the outputs hold such a result.
- R7: At an edge with `ed`=0 and `start`=0, the counter, the pipeline, `rdy`, `dor` and `doi` all keep their values.
- R8: With INVERSE=1, the conjugate twiddle is used: wi = +sn. Everything else follows R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Restarts the coefficient sequence at entry 0 |
| ed | input | 1 | Sample strobe and pipeline enable |
| dr | input | DATA_W | Input sample, real part |
| di | input | DATA_W | Input sample, imaginary part |
| rdy | output | 1 | Output holds a valid rotated sample |
| dor | output | DATA_W | Rotated sample, real part |
| doi | output | DATA_W | Rotated sample, imaginary part |

## Verification
A result is due after the third enabled edge, counting the edge that accepts the sample. Edges with the enable low do not count, so the due time is measured in enabled edges rather than wall-clock cycles. The bench keeps its own three-slot model that shifts only on enabled edges, with empty slots for start edges. It compares `rdy` and the outputs at the falling edge after every rising edge, against the model's oldest slot. A forward instance and an inverse instance receive the same stimulus, with directed runs across the 127→0 wrap, restarts with and without the enable, and a reset in the middle of a stream.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int ADDR_W = 7;
  localparam int TABLE_N = 1 << ADDR_W;
  localparam int COL_BITS = 4;
  localparam int PIPE_LAT = 3;

  typedef struct packed {
    logic advance;
    logic take;
    logic clear;
  } rotStrobe_t;
endpackage

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ed,
  output rotStrobe_t        strb,
  output logic [ADDR_W-1:0] addr,
  output logic              rdy
);
  logic [ADDR_W-1:0] cntQ;
  logic [PIPE_LAT-1:0] validQ;

  always_comb begin
    strb.advance = ed;
    strb.take    = ed & ~start;
    strb.clear   = start;
  end

  // R1 reset clears counter and valid chain; R2 restart; R3 step
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= '0;
      validQ <= '0;
    end else begin
      if (start)   cntQ <= '0;
      else if (ed) cntQ <= cntQ + 1'b1;
      if (ed) validQ <= {validQ[PIPE_LAT-2:0], strb.take};
    end
  end

  assign addr = cntQ;
  assign rdy  = validQ[PIPE_LAT-1];

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (cntQ == '0));
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ed && !start) |=> (cntQ == $past(cntQ) + 1'b1));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ed && !start) |=> ($stable(cntQ) && $stable(rdy)));
  p_start_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    (start && ed) |=> !validQ[0]);
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  rotStrobe_t               strb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [DATA_W-1:0] dr,
  input  logic signed [DATA_W-1:0] di,
  output logic signed [DATA_W-1:0] dor,
  output logic signed [DATA_W-1:0] doi
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int MAXC   = (1 << (COEF_W - 1)) - 1;
  localparam real SCALE = 2.0 ** (COEF_W - 1);
  localparam real PI    = 3.14159265358979323846;

  function automatic int roundHalf(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction

  function automatic int satCode(real x);
    int v;
    v = roundHalf(x * SCALE);
    if (v > MAXC) v = MAXC;
    return v;
  endfunction

  function automatic int cosCode(int e);
    return satCode($cos(2.0 * PI * e / TABLE_N));
  endfunction

  function automatic int sinCode(int e);
    return satCode($sin(2.0 * PI * e / TABLE_N));
  endfunction

  logic signed [COEF_W-1:0] romRe [TABLE_N];
  logic signed [COEF_W-1:0] romIm [TABLE_N];

  // R3 exponent = row * column of the 8x16 grid; R4/R8 coefficient codes
  for (genvar g = 0; g < TABLE_N; g++) begin : gRom
    localparam int EXPO  = ((g >> COL_BITS) * (g % (1 << COL_BITS))) % TABLE_N;
    localparam int COS_C = cosCode(EXPO);
    localparam int SIN_C = sinCode(EXPO);
    assign romRe[g] = COEF_W'(COS_C);
    if (INVERSE) begin : gInv
      assign romIm[g] = COEF_W'(SIN_C);
    end else begin : gFwd
      assign romIm[g] = COEF_W'(-SIN_C);
    end
  end

  logic signed [DATA_W-1:0] arQ, aiQ;
  logic signed [COEF_W-1:0] wrQ, wiQ;
  logic signed [PROD_W-1:0] pRrQ, pIiQ, pRiQ, pIrQ;
  logic signed [SUM_W-1:0]  sumRe, sumIm, shRe, shIm;

  always_comb begin
    sumRe = SUM_W'(pRrQ) - SUM_W'(pIiQ);
    sumIm = SUM_W'(pRiQ) + SUM_W'(pIrQ);
    shRe  = sumRe >>> (COEF_W - 1);
    shIm  = sumIm >>> (COEF_W - 1);
  end

  // R5/R6: capture, multiply, add/scale; R7: hold while not advancing
  always_ff @(posedge clk) begin
    if (rst) begin
      arQ <= '0; aiQ <= '0; wrQ <= '0; wiQ <= '0;
      pRrQ <= '0; pIiQ <= '0; pRiQ <= '0; pIrQ <= '0;
      dor <= '0; doi <= '0;
    end else if (strb.advance) begin
      arQ  <= dr;
      aiQ  <= di;
      wrQ  <= romRe[addr];
      wiQ  <= romIm[addr];
      pRrQ <= PROD_W'(arQ) * PROD_W'(wrQ);
      pIiQ <= PROD_W'(aiQ) * PROD_W'(wiQ);
      pRiQ <= PROD_W'(arQ) * PROD_W'(wiQ);
      pIrQ <= PROD_W'(aiQ) * PROD_W'(wrQ);
      dor  <= shRe[DATA_W-1:0];
      doi  <= shIm[DATA_W-1:0];
    end
  end

  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> ($stable(dor) && $stable(doi)));
  p_row0_unity_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && addr[ADDR_W-1:COL_BITS] == '0) |=>
      (wrQ == COEF_W'(MAXC) && wiQ == '0));
endmodule

// File: rtl/twiddle_rotator.sv
module twiddle_rotator
  import rot_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ed,
  input  logic [DATA_W-1:0] dr,
  input  logic [DATA_W-1:0] di,
  output logic              rdy,
  output logic [DATA_W-1:0] dor,
  output logic [DATA_W-1:0] doi
);
  rotStrobe_t        strb;
  logic [ADDR_W-1:0] addr;

  rot_ctrl uCtrl (
    .clk(clk), .rst(rst), .start(start), .ed(ed),
    .strb(strb), .addr(addr), .rdy(rdy)
  );

  rot_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W), .INVERSE(INVERSE)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr),
    .dr(dr), .di(di), .dor(dor), .doi(doi)
  );
endmodule

// File: tb/twiddle_rotator_test.sv
module twiddle_rotator_test;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int MAXC = (1 << (CW - 1)) - 1;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst, start, ed;
  logic [DW-1:0] dr, di;
  logic rdy, rdyI;
  logic [DW-1:0] dor, doi, dorI, doiI;

  int checks = 0;
  int fails = 0;

  always #5ns clk = ~clk;

  twiddle_rotator #(.DATA_W(DW), .COEF_W(CW), .INVERSE(1'b0)) uut (
    .clk(clk), .rst(rst), .start(start), .ed(ed), .dr(dr), .di(di),
    .rdy(rdy), .dor(dor), .doi(doi));
  twiddle_rotator #(.DATA_W(DW), .COEF_W(CW), .INVERSE(1'b1)) uutInv (
    .clk(clk), .rst(rst), .start(start), .ed(ed), .dr(dr), .di(di),
    .rdy(rdyI), .dor(dorI), .doi(doiI));

  // bench model of the pipeline
  int mCnt = 0;
  bit mV [3];
  logic [DW-1:0] mRe [3], mIm [3], mReI [3], mImI [3];

  function automatic longint rnd(real x);
    if (x >= 0.0) return longint'($rtoi(x + 0.5));
    else          return -longint'($rtoi(0.5 - x));
  endfunction

  function automatic longint sat(longint v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  function automatic logic [DW-1:0] rot(int k, logic [DW-1:0] a, logic [DW-1:0] b,
                                        bit inv, bit imagPart);
    int e;
    real th;
    longint wr, sn, wi, ar, ai, r;
    e  = ((k >> 4) * (k & 15)) % 128;
    th = 2.0 * PI * e / 128.0;
    wr = sat(rnd($cos(th) * (2.0 ** (CW - 1))));
    sn = sat(rnd($sin(th) * (2.0 ** (CW - 1))));
    wi = inv ? sn : -sn;
    ar = longint'($signed(a));
    ai = longint'($signed(b));
    r  = imagPart ? (ar * wi + ai * wr) : (ar * wr - ai * wi);
    r  = r >>> (CW - 1);
    return r[DW-1:0];
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit r, bit s, bit e, logic [DW-1:0] a, logic [DW-1:0] b);
    rst = r; start = s; ed = e; dr = a; di = b;
    @(posedge clk);
    if (r) begin
      mCnt = 0;
      for (int i = 0; i < 3; i++) mV[i] = 1'b0;
    end else begin
      if (e) begin
        for (int i = 2; i > 0; i--) begin
          mV[i] = mV[i-1]; mRe[i] = mRe[i-1]; mIm[i] = mIm[i-1];
          mReI[i] = mReI[i-1]; mImI[i] = mImI[i-1];
        end
        mV[0] = !s;
        mRe[0]  = rot(mCnt, a, b, 1'b0, 1'b0);
        mIm[0]  = rot(mCnt, a, b, 1'b0, 1'b1);
        mReI[0] = rot(mCnt, a, b, 1'b1, 1'b0);
        mImI[0] = rot(mCnt, a, b, 1'b1, 1'b1);
      end
      if (s)      mCnt = 0;
      else if (e) mCnt = (mCnt + 1) % 128;
    end
    @(negedge clk);
    check(tag, {15'd0, rdy}, {15'd0, mV[2]}, "rdy (R6)");
    check(tag, {15'd0, rdyI}, {15'd0, mV[2]}, "rdy inverse (R6)");
    if (mV[2]) begin
      check(tag, dor, mRe[2], "dor (R5)");
      check(tag, doi, mIm[2], "doi (R5)");
      check(tag, dorI, mReI[2], "dor inverse (R8)");
      check(tag, doiI, mImI[2], "doi inverse (R8)");
    end
  endtask

  function automatic logic [DW-1:0] pick(int i);
    case (i % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'hFFFF;
      default: return DW'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000ns;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedSink;
    seedSink = $urandom(32'd4242);
    rst = 1'b1; start = 1'b0; ed = 1'b0; dr = '0; di = '0;
    @(negedge clk);
    // R1: reset state
    step("R1", 1, 0, 1, 16'h1234, 16'h4321);
    step("R1", 1, 0, 1, 16'h1234, 16'h4321);
    // R2: restart, then full pass across the 127->0 wrap (R3 R4)
    step("R2", 0, 1, 1, 16'h7FFF, 16'h7FFF);
    for (int i = 0; i < 140; i++) step("R3", 0, 0, 1, pick(i), pick(i + 3));
    for (int i = 0; i < 8; i++) step("R4", 0, 0, 1, 16'h8000, 16'h8000);
    // R7: random enable gaps
    for (int i = 0; i < 150; i++)
      step("R7", 0, 0, bit'($urandom % 2), DW'($urandom), DW'($urandom));
    // R2: restart mid-stream with enable high
    step("R2", 0, 1, 1, 16'h5555, 16'hAAAA);
    for (int i = 0; i < 20; i++) step("R2", 0, 0, 1, DW'($urandom), DW'($urandom));
    // R2 R7: restart while enable low, idle, then resume
    step("R2", 0, 1, 0, 16'h1111, 16'h2222);
    for (int i = 0; i < 4; i++) step("R7", 0, 0, 0, DW'($urandom), DW'($urandom));
    for (int i = 0; i < 24; i++) step("R2", 0, 0, 1, DW'($urandom), DW'($urandom));
    // R1: reset mid-stream, resume without start
    step("R1", 1, 0, 1, 16'h0F0F, 16'hF0F0);
    for (int i = 0; i < 40; i++)
      step("R1", 0, 0, bit'($urandom % 4 != 0), DW'($urandom), DW'($urandom));
    // R6: drain
    for (int i = 0; i < 4; i++) step("R6", 0, 0, 1, 16'h0000, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule